// File: doc/BRIEF.md
# Bundle Issue Gate

This block sits in the decode stage of an in-order core that can issue up to three instructions per cycle. Each cycle it is shown a bundle: a length (zero to three) and a class code for each lane slot. It decides whether that bundle can go down the lanes together under the lane rules of the current pipeline mode. Software sets the mode through a small write port, and the written value is held in a register.

The lanes are not alike. Lane 1 takes every class. Lane 2 takes simple integer, shift and convert work, and it also takes floating-point work when lane 1 holds none. Lane 3 takes only simple integer work and a reduced class of conversions. A memory operation is only legal in lane 1, and it also takes up one further lane, so it leaves less room for companions.

When a bundle does not fit, no fault is raised. The gate drops to serial issue instead. It accepts only lane 1 on each cycle that holds an instruction, until every instruction of the split bundle has gone. Upstream is expected to shift the remaining instructions down into lane 1 after each accept.

Top module: `issue_bundle_gate`

## Requirements
- R1: While reset is asserted and on leaving it, the gate is not in serial drain and the mode register holds 0. With bundle length 0 the gate drives accept=000, fallback=0 and bundle_ok=0.
- R2: A value on mode_wdata with mode_we high is stored on the rising clock edge and governs bundles from the next cycle on. The bundle shown in the write cycle is judged under the old mode. Mode codes: 0 is scalar (1 lane), 1 is dual (2 lanes), 2 is triple (3 lanes), and 3 is reserved and behaves as 0.
- R3: In modes 0 and 3, every bundle of length 2 or more is split. A bundle of length 1 always issues.
- R4: Class codes are ALU=0, SHIFT=1, CVT=2, CVT_LITE=3, MEM=4, FPU=5, BRANCH=6, OTHER=7. Lane 1 (bits [2:0]) accepts every code. Lane 2 (bits [5:3]) accepts ALU, SHIFT, CVT and CVT_LITE. Lane 3 (bits [8:6]) accepts only ALU and CVT_LITE.
- R5: FPU in lane 2 is legal only when lane 1 does not hold FPU.
- R6: MEM is legal only in lane 1, and it uses one extra lane. In mode 1 it must issue alone. In mode 2 a bundle with MEM in lane 1 may have at most length 2.
- R7: A bundle longer than the lane count of the current mode is split.
- R8: A legal bundle issues whole in one cycle: accept has bit i set for every lane i below the length, bundle_ok=1 and fallback=0. Class codes in lanes at or above the length have no effect.
- R9: A bundle of length N that breaks a rule starts serial issue. In that cycle and in each following cycle that presents an instruction, accept=001, fallback=1 and bundle_ok=0, for N instruction-bearing cycles in total. This holds even when the remaining instructions would form a legal bundle. After that, parallel judging resumes.
- R10: A cycle with length 0 during serial drain gives accept=000 and keeps fallback=1. It does not count towards the drain.
- R11: Outside serial drain, a cycle with length 0 gives accept=000, fallback=0 and bundle_ok=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value to store |
| bundle_len | input | 2 | Number of instructions in the bundle, lanes filled from lane 1 |
| lane_cls | input | 9 | Class code per lane, 3 bits each, lane 1 in the low bits |
| accept | output | 3 | Lanes issued this cycle |
| fallback | output | 1 | Serial issue in progress |
| bundle_ok | output | 1 | Whole bundle issued in parallel this cycle |

## Verification
The hardest case to reach is a serial drain whose remainder would itself be legal, especially when bubbles fall in the middle of it. Only a split bundle followed by the right shifted remainders produces it. The bench drives every class combination for every mode and length. For each split bundle it replays the shifted remainders exactly as upstream would, so remainders that would be legal on their own are covered many times. A directed sequence also inserts empty cycles into a drain and writes the mode in the same cycle as a bundle.

// File: rtl/ibg_pkg.sv
package ibg_pkg;

   typedef enum logic [2:0] {
      CL_ALU      = 3'd0,
      CL_SHIFT    = 3'd1,
      CL_CVT      = 3'd2,
      CL_CVT_LITE = 3'd3,
      CL_MEM      = 3'd4,
      CL_FPU      = 3'd5,
      CL_BRANCH   = 3'd6,
      CL_OTHER    = 3'd7
   } iclass_e;

   typedef enum logic [1:0] {
      MD_SCALAR = 2'd0,
      MD_DUAL   = 2'd1,
      MD_TRIPLE = 2'd2,
      MD_RSVD   = 2'd3
   } imode_e;

   // Number of lanes that a mode opens; the reserved code falls back to scalar.
   function automatic int lanes_in_mode(input logic [1:0] m);
      case (m)
         MD_DUAL:   return 2;
         MD_TRIPLE: return 3;
         default:   return 1;
      endcase
   endfunction

endpackage

// File: rtl/ibg_mode_reg.sv
module ibg_mode_reg #(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [MODE_W-1:0] wdata,
   output logic [MODE_W-1:0] mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mode_q <= '0;
      else if (we) mode_q <= wdata;
   end

endmodule

// File: rtl/ibg_lane_cap.sv
module ibg_lane_cap
   import ibg_pkg::*;
#(
   parameter int LANE  = 0,
   parameter int CLS_W = 3
) (
   input  logic [CLS_W-1:0] cls,
   input  logic             lead_is_fpu,
   output logic             ok
);

   generate
      if (LANE > 2) begin : g_bad_lane
         $error("ibg_lane_cap: no capability defined for lane index %0d", LANE);
      end
   endgenerate

   always_comb begin
      // Lane 1 takes anything; further lanes start from "reject".
      ok = (LANE == 0);
      if (cls == CLS_W'(CL_ALU) || cls == CLS_W'(CL_CVT_LITE)) begin
         ok = 1'b1;
      end else if (cls == CLS_W'(CL_SHIFT) || cls == CLS_W'(CL_CVT)) begin
         ok = (LANE <= 1);
      end else if (cls == CLS_W'(CL_FPU)) begin
         ok = (LANE == 0) || ((LANE == 1) && !lead_is_fpu);
      end
   end

endmodule

// File: rtl/ibg_rules.sv
module ibg_rules
   import ibg_pkg::*;
#(
   parameter int NUM_LANES = 3,
   parameter int CLS_W     = 3,
   parameter int MODE_W    = 2,
   parameter int LEN_W     = 2
) (
   input  logic [MODE_W-1:0]          mode,
   input  logic [LEN_W-1:0]           len,
   input  logic [NUM_LANES*CLS_W-1:0] cls_flat,
   output logic                       legal
);

   logic [CLS_W-1:0]     cls [NUM_LANES];
   logic [NUM_LANES-1:0] cap_ok;
   logic [NUM_LANES-1:0] slot_ok;
   logic                 lead_fpu;
   logic                 lead_mem;

   assign lead_fpu = (cls[0] == CLS_W'(CL_FPU));
   assign lead_mem = (cls[0] == CLS_W'(CL_MEM));

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LANES; gi++) begin : g_lane
         assign cls[gi] = cls_flat[gi*CLS_W +: CLS_W];
         ibg_lane_cap #(.LANE(gi), .CLS_W(CLS_W)) u_cap (
            .cls         (cls[gi]),
            .lead_is_fpu ((gi == 0) ? 1'b0 : lead_fpu),
            .ok          (cap_ok[gi])
         );
         // Slots past the bundle length are don't-care.
         assign slot_ok[gi] = (int'(len) <= gi) || cap_ok[gi];
      end
   endgenerate

   always_comb begin
      int width;
      logic fits;
      logic mem_room;
      width    = lanes_in_mode(mode[1:0]);
      fits     = (int'(len) <= width);
      // A lead memory op occupies one more lane than it sits in.
      mem_room = !(lead_mem && (len > 1) && (int'(len) + 1 > width));
      legal    = fits && mem_room && (&slot_ok);
   end

endmodule

// File: rtl/ibg_drain.sv
module ibg_drain #(
   parameter int NUM_LANES = 3,
   parameter int LEN_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LEN_W-1:0]     len,
   input  logic                 legal,
   output logic [NUM_LANES-1:0] accept,
   output logic                 fallback,
   output logic                 bundle_ok,
   output logic                 draining
);

   localparam logic [NUM_LANES-1:0] LEAD_ONLY = NUM_LANES'(1);

   typedef enum logic {ST_PAR = 1'b0, ST_SER = 1'b1} st_e;

   st_e                  st_q, st_d;
   logic [LEN_W-1:0]     rem_q, rem_d;
   logic [NUM_LANES-1:0] len_mask;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LANES; gi++) begin : g_mask
         assign len_mask[gi] = (int'(len) > gi);
      end
   endgenerate

   always_comb begin
      st_d      = st_q;
      rem_d     = rem_q;
      accept    = '0;
      fallback  = 1'b0;
      bundle_ok = 1'b0;
      if (st_q == ST_SER) begin
         fallback = 1'b1;
         if (len != '0) begin
            accept = LEAD_ONLY;
            rem_d  = rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) st_d = ST_PAR;
         end
      end else if (len != '0) begin
         if (legal) begin
            accept    = len_mask;
            bundle_ok = 1'b1;
         end else begin
            accept   = LEAD_ONLY;
            fallback = 1'b1;
            if (len > LEN_W'(1)) begin
               st_d  = ST_SER;
               rem_d = len - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_PAR;
         rem_q <= '0;
      end else begin
         st_q  <= st_d;
         rem_q <= rem_d;
      end
   end

   assign draining = (st_q == ST_SER);

endmodule

// File: rtl/issue_bundle_gate.sv
module issue_bundle_gate #(
   parameter int NUM_LANES = 3,
   parameter int CLS_W     = 3,
   parameter int MODE_W    = 2,
   parameter int LEN_W     = $clog2(NUM_LANES + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_we,
   input  logic [MODE_W-1:0]          mode_wdata,
   input  logic [LEN_W-1:0]           bundle_len,
   input  logic [NUM_LANES*CLS_W-1:0] lane_cls,
   output logic [NUM_LANES-1:0]       accept,
   output logic                       fallback,
   output logic                       bundle_ok
);

   generate
      if (NUM_LANES != 3) begin : g_bad_lanes
         $error("issue_bundle_gate: lane rules are defined for exactly 3 lanes");
      end
      if (CLS_W < 3) begin : g_bad_cls
         $error("issue_bundle_gate: class field must hold at least 3 bits");
      end
      if (MODE_W != 2) begin : g_bad_mode
         $error("issue_bundle_gate: mode field must be 2 bits");
      end
      if (LEN_W < $clog2(NUM_LANES + 1)) begin : g_bad_len
         $error("issue_bundle_gate: length field too narrow");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   logic              legal;
   logic              draining;

   ibg_mode_reg #(.MODE_W(MODE_W)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (mode_we),
      .wdata  (mode_wdata),
      .mode_q (mode_q)
   );

   ibg_rules #(
      .NUM_LANES (NUM_LANES),
      .CLS_W     (CLS_W),
      .MODE_W    (MODE_W),
      .LEN_W     (LEN_W)
   ) u_rules (
      .mode     (mode_q),
      .len      (bundle_len),
      .cls_flat (lane_cls),
      .legal    (legal)
   );

   ibg_drain #(
      .NUM_LANES (NUM_LANES),
      .LEN_W     (LEN_W)
   ) u_drain (
      .clk       (clk),
      .rst_n     (rst_n),
      .len       (bundle_len),
      .legal     (legal),
      .accept    (accept),
      .fallback  (fallback),
      .bundle_ok (bundle_ok),
      .draining  (draining)
   );

endmodule

// File: rtl/issue_bundle_gate_props.sv
module issue_bundle_gate_props
   import ibg_pkg::*;
#(
   parameter int NUM_LANES = 3,
   parameter int CLS_W     = 3,
   parameter int MODE_W    = 2,
   parameter int LEN_W     = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [LEN_W-1:0]           bundle_len,
   input logic [NUM_LANES*CLS_W-1:0] lane_cls,
   input logic [NUM_LANES-1:0]       accept,
   input logic                       fallback,
   input logic                       bundle_ok,
   input logic [MODE_W-1:0]          mode_q,
   input logic                       draining
);

   logic [CLS_W-1:0] c0, c1, c2;
   assign c0 = lane_cls[0*CLS_W +: CLS_W];
   assign c1 = lane_cls[1*CLS_W +: CLS_W];
   assign c2 = lane_cls[2*CLS_W +: CLS_W];

   always_comb begin
      if (!rst_n) begin
         assert_idle_in_reset_R1: assert (!draining);
      end
   end

   assert_scalar_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bundle_ok && (mode_q == MODE_W'(0) || mode_q == MODE_W'(3))) |-> (bundle_len == LEN_W'(1)));

   assert_lane3_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bundle_ok && bundle_len == LEN_W'(3)) |-> (c2 == CLS_W'(CL_ALU) || c2 == CLS_W'(CL_CVT_LITE)));

   assert_fpu_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bundle_ok && bundle_len >= LEN_W'(2) && c0 == CLS_W'(CL_FPU)) |-> (c1 != CLS_W'(CL_FPU)));

   assert_mem_extra_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bundle_ok && bundle_len >= LEN_W'(2) && c0 == CLS_W'(CL_MEM)) |-> (mode_q == MODE_W'(2) && bundle_len == LEN_W'(2)));

   assert_dual_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bundle_ok && mode_q == MODE_W'(1)) |-> (bundle_len <= LEN_W'(2)));

   assert_whole_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bundle_ok |-> (!fallback && $countones(accept) == int'(bundle_len)));

   assert_lead_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fallback |-> (accept[NUM_LANES-1:1] == '0 && !bundle_ok));

   assert_drain_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      draining |-> fallback);

   assert_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fallback && bundle_len == '0) |-> (accept == '0));

   assert_idle_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!draining && bundle_len == '0) |-> (!fallback && !bundle_ok && accept == '0));

endmodule

bind issue_bundle_gate issue_bundle_gate_props #(
   .NUM_LANES (NUM_LANES),
   .CLS_W     (CLS_W),
   .MODE_W    (MODE_W),
   .LEN_W     (LEN_W)
) u_props (
   .clk        (clk),
   .rst_n      (rst_n),
   .bundle_len (bundle_len),
   .lane_cls   (lane_cls),
   .accept     (accept),
   .fallback   (fallback),
   .bundle_ok  (bundle_ok),
   .mode_q     (mode_q),
   .draining   (draining)
);

// File: tb/sim_issue_bundle_gate.sv
`timescale 1ns/1ps
module sim_issue_bundle_gate;

   localparam int FILL = 4; // filler class for unused slots (MEM)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_we = 1'b0;
   logic [1:0] mode_wdata = 2'd0;
   logic [1:0] bundle_len = 2'd0;
   logic [8:0] lane_cls = 9'd0;
   logic [2:0] accept;
   logic       fallback;
   logic       bundle_ok;

   int checks = 0;
   int failures = 0;
   int mode_ref = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   issue_bundle_gate u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_we    (mode_we),
      .mode_wdata (mode_wdata),
      .bundle_len (bundle_len),
      .lane_cls   (lane_cls),
      .accept     (accept),
      .fallback   (fallback),
      .bundle_ok  (bundle_ok)
   );

   function automatic bit ref_legal(int m, int len, int c0, int c1, int c2);
      int w;
      logic [7:0] l2_tab;
      logic [7:0] l3_tab;
      w      = (m == 1) ? 2 : (m == 2) ? 3 : 1;
      l2_tab = 8'b0000_1111 | ((c0 != 5) ? 8'b0010_0000 : 8'b0);
      l3_tab = 8'b0000_1001;
      if (len > w) return 1'b0;
      if (len >= 2 && !l2_tab[c1]) return 1'b0;
      if (len == 3 && !l3_tab[c2]) return 1'b0;
      if (c0 == 4 && len > 1 && len + 1 > w) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk(string tag, logic [2:0] e_acc, logic e_fb, logic e_ok);
      checks++;
      if (accept !== e_acc || fallback !== e_fb || bundle_ok !== e_ok) begin
         failures++;
         $display("FAIL %s: got acc=%b fb=%b ok=%b exp acc=%b fb=%b ok=%b (mode %0d len %0d cls %h)",
                  tag, accept, fallback, bundle_ok, e_acc, e_fb, e_ok, mode_ref, bundle_len, lane_cls);
      end
   endtask

   task automatic present(int len, int c0, int c1, int c2);
      bundle_len = 2'(len);
      lane_cls   = {3'(c2), 3'(c1), 3'(c0)};
      #1;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_mode(int m);
      mode_we    = 1'b1;
      mode_wdata = 2'(m);
      bundle_len = 2'd0;
      step();
      mode_we  = 1'b0;
      mode_ref = m;
   endtask

   // Presents one bundle and, when split, the shifted remainders.
   task automatic run_bundle(string tag, int len, int c0, int c1, int c2);
      int c[3];
      c[0] = c0; c[1] = c1; c[2] = c2;
      for (int j = len; j < 3; j++) c[j] = FILL;
      if (ref_legal(mode_ref, len, c[0], c[1], c[2])) begin
         present(len, c[0], c[1], c[2]);
         chk(tag, 3'((1 << len) - 1), 1'b0, 1'b1);
         step();
      end else begin
         for (int k = 0; k < len; k++) begin
            int s[3];
            for (int j = 0; j < 3; j++) s[j] = (j + k < len) ? c[j + k] : FILL;
            present(len - k, s[0], s[1], s[2]);
            chk(tag, 3'b001, 1'b1, 1'b0);
            step();
         end
      end
   endtask

   task automatic t_reset();
      present(0, 0, 0, 0);
      chk("R1 in reset", 3'b000, 1'b0, 1'b0);
      step();
      rst_n = 1'b1;
      present(0, 0, 0, 0);
      chk("R1 after reset", 3'b000, 1'b0, 1'b0);
      step();
      run_bundle("R1 default mode scalar", 2, 0, 0, FILL);
   endtask

   task automatic t_mode_write();
      // Write mode 2 in the same cycle as a pair: old mode 0 still rules.
      mode_we    = 1'b1;
      mode_wdata = 2'd2;
      present(2, 0, 0, FILL);
      chk("R2 old mode in write cycle", 3'b001, 1'b1, 1'b0);
      step();
      mode_we  = 1'b0;
      mode_ref = 2;
      present(1, 0, FILL, FILL);
      chk("R2 drain tail", 3'b001, 1'b1, 1'b0);
      step();
      run_bundle("R2 triple after write", 3, 0, 1, 3);
      write_mode(3);
      run_bundle("R2 reserved acts scalar", 2, 0, 0, FILL);
      run_bundle("R3 reserved single", 1, 6, FILL, FILL);
      write_mode(0);
      run_bundle("R3 scalar triple", 3, 0, 0, 0);
   endtask

   task automatic t_lanes();
      write_mode(2);
      run_bundle("R4 lane caps ok", 3, 6, 2, 3);
      run_bundle("R4 shift in lane3", 3, 0, 0, 1);
      run_bundle("R4 full cvt in lane3", 3, 0, 0, 2);
      run_bundle("R4 branch in lane2", 2, 0, 6, FILL);
   endtask

   task automatic t_fpu();
      write_mode(1);
      run_bundle("R5 fpu lane2 ok", 2, 0, 5, FILL);
      run_bundle("R5 fpu pair", 2, 5, 5, FILL);
      write_mode(2);
      run_bundle("R5 fpu lane2 triple", 3, 6, 5, 0);
   endtask

   task automatic t_mem();
      write_mode(1);
      run_bundle("R6 mem alone dual", 1, 4, FILL, FILL);
      run_bundle("R6 mem pair dual", 2, 4, 0, FILL);
      write_mode(2);
      run_bundle("R6 mem pair triple", 2, 4, 0, FILL);
      run_bundle("R6 mem with lane3", 3, 4, 0, 0);
      run_bundle("R6 mem in lane2", 2, 0, 4, FILL);
   endtask

   task automatic t_width();
      write_mode(1);
      run_bundle("R7 three in dual", 3, 0, 0, 0);
   endtask

   task automatic t_ignore();
      write_mode(2);
      present(1, 0, 5, 5);
      chk("R8 unused slots ignored len1", 3'b001, 1'b0, 1'b1);
      step();
      present(2, 0, 1, 4);
      chk("R8 unused slot ignored len2", 3'b011, 1'b0, 1'b1);
      step();
   endtask

   task automatic t_bubble();
      write_mode(0);
      present(3, 0, 0, 0);
      chk("R9 split start", 3'b001, 1'b1, 1'b0);
      step();
      present(0, 0, 0, 0);
      chk("R10 bubble in drain", 3'b000, 1'b1, 1'b0);
      step();
      present(2, 0, 0, FILL);
      chk("R9 drain second", 3'b001, 1'b1, 1'b0);
      step();
      present(0, 0, 0, 0);
      chk("R10 second bubble", 3'b000, 1'b1, 1'b0);
      step();
      present(1, 0, FILL, FILL);
      chk("R9 drain last", 3'b001, 1'b1, 1'b0);
      step();
      present(0, 0, 0, 0);
      chk("R11 idle after drain", 3'b000, 1'b0, 1'b0);
      step();
   endtask

   task automatic t_exhaustive();
      for (int m = 0; m < 4; m++) begin
         write_mode(m);
         for (int len = 1; len <= 3; len++) begin
            for (int a = 0; a < 8; a++) begin
               for (int b = 0; b < ((len >= 2) ? 8 : 1); b++) begin
                  for (int d = 0; d < ((len == 3) ? 8 : 1); d++) begin
                     run_bundle("R9 exhaustive", len, a, b, d);
                  end
               end
            end
         end
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_mode_write();
      t_lanes();
      t_fpu();
      t_mem();
      t_width();
      t_ignore();
      t_bubble();
      t_exhaustive();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule